// File: doc/BRIEF.md
# Phase-Indexed Microcode Control Decoder

This block turns the opcode of an 8-bit instruction word into sixteen control lines, selected separately for each of the three active phases of a four-phase instruction cycle. The lines come from a small writable table, so the meaning of every opcode in every phase can be changed by rewriting entries, with no change to the decoding logic. At reset the table takes a fixed default content.

Beside the control lines, the block decides whether the program counter is to be reloaded. Two bits of a table entry work together: one requests an unconditional jump, and a three-bit field picks which condition flags may trigger a jump. The flags themselves are set by a separate instruction run just before the branch. The jump target is the low operand field of the instruction. A load request is only raised in the last phase, and only while the trigger strobe is high.

Top module: `ucode_decoder`

## Requirements
- R1: The opcode is instr_i[7:5]. pc_target_o always equals the operand field instr_i[4:0].
- R2: With phase_i = 0 (phase A), ctrl_o is all zero and pc_load_o is 0, whatever the table holds.
- R3: With phase_i = 1, 2 or 3 (B, C, D), ctrl_o shows, in the same cycle, the table entry addressed by the opcode and that phase.
- R4: A clock edge with rst_n low loads the default table. For opcode o < 6 and phase p in 1..3, the entry has only bit (3*o + p - 1) mod 12 set. Opcode 6 has 0x8000 in phase 3 and zero in phases 1 and 2. Opcode 7 has 0x7000 in phase 3 and zero in phases 1 and 2.
- R5: A write happens at a rising edge with tbl_we_i high. It replaces the entry (tbl_op_i, tbl_ph_i) with tbl_data_i. The old value is still shown during the write cycle, and the new value appears from the next cycle on.
- R6: A write with tbl_ph_i = 0 changes no entry.
- R7: Bit 15 of the current entry is the unconditional jump bit. If it is set, phase_i = 3 and trig_i = 1 raise pc_load_o.
- R8: Bits 14, 13 and 12 of the current entry enable a jump on flag_gt_i, flag_eq_i and flag_lt_i. In phase 3 with trig_i = 1, pc_load_o rises when any enabled flag is 1.
- R9: If bit 15 is clear and no enabled flag is 1, pc_load_o stays 0 in phase 3. Execution then continues at the address already incremented.
- R10: pc_load_o is 0 whenever trig_i = 0 or phase_i is not 3, even if the entry has jump bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the default table |
| instr_i | input | 8 | Instruction word: opcode in 7:5, operand in 4:0 |
| phase_i | input | 2 | Current phase: 0=A, 1=B, 2=C, 3=D |
| trig_i | input | 1 | Transfer strobe inside the phase |
| flag_gt_i | input | 1 | Greater-than-zero flag |
| flag_eq_i | input | 1 | Equal-to-zero flag |
| flag_lt_i | input | 1 | Less-than-zero flag |
| tbl_we_i | input | 1 | Table write enable |
| tbl_op_i | input | 3 | Opcode of the entry to write |
| tbl_ph_i | input | 2 | Phase of the entry to write (0 ignored) |
| tbl_data_i | input | 16 | Entry value to write |
| ctrl_o | output | 16 | Control lines for the current phase |
| pc_load_o | output | 1 | Program-counter load request |
| pc_target_o | output | 5 | Jump target address |

## Verification
A table write can land on the very entry being decoded in the same cycle. That entry can also be a phase-D entry whose new content changes the jump decision. The bench rewrites the phase-D entry of the opcode under decode while the decode is running. It expects the old lines and the old load decision in the write cycle, and the new ones in the following cycle. A jump is also made to share its cycle with a write to some other entry, to show that the write does not disturb the decode in progress.

// File: rtl/ucd_pkg.sv
// Shared constants, phase encoding and default table content for the
// microcode decoder. Assumes three active phases following an idle phase A.
package ucd_pkg;
    parameter int CTRL_W  = 16;
    parameter int OP_W    = 3;
    parameter int ARG_W   = 5;
    parameter int INSTR_W = OP_W + ARG_W;
    parameter int PH_W    = 2;
    parameter int NUM_ACT = 3;
    localparam int NUM_OP   = 1 << OP_W;
    localparam int GEN_BITS = 12;
    localparam int BIT_JMP  = 15;
    localparam int BIT_CGT  = 14;
    localparam int BIT_CEQ  = 13;
    localparam int BIT_CLT  = 12;

    typedef enum logic [PH_W-1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2,
        PH_D = 2'd3
    } phase_e;

    // Default entry for opcode op and active phase index act (0 = B).
    function automatic logic [CTRL_W-1:0] dflt_entry(input int op, input int act);
        logic [CTRL_W-1:0] v;
        v = '0;
        if (op < NUM_OP - 2) begin
            v[(3 * op + act) % GEN_BITS] = 1'b1;
        end else if (op == NUM_OP - 2) begin
            if (act == NUM_ACT - 1) v[BIT_JMP] = 1'b1;
        end else begin
            if (act == NUM_ACT - 1) begin
                v[BIT_CGT] = 1'b1;
                v[BIT_CEQ] = 1'b1;
                v[BIT_CLT] = 1'b1;
            end
        end
        return v;
    endfunction
endpackage

// File: rtl/ucd_table.sv
// Writable control table, one entry per opcode and active phase.
// Assumes phase code 0 has no entries; writes to it are dropped and
// reads of it return zero. Read is combinational, write is registered.
module ucd_table
    import ucd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [OP_W-1:0]   wop_i,
    input  logic [PH_W-1:0]   wph_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic [OP_W-1:0]   rop_i,
    input  logic [PH_W-1:0]   rph_i,
    output logic [CTRL_W-1:0] rdata_o
);
    logic [CTRL_W-1:0] mem [NUM_OP][NUM_ACT];

    for (genvar g = 0; g < NUM_OP; g++) begin : g_op
        for (genvar a = 0; a < NUM_ACT; a++) begin : g_act
            // Reload default on reset, otherwise take an addressed write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[g][a] <= dflt_entry(g, a);
                end else if (we_i && wop_i == OP_W'(g) && wph_i == PH_W'(a + 1)) begin
                    mem[g][a] <= wdata_i;
                end
            end
        end
    end

    // Select the entry for the current opcode and phase; phase A reads zero.
    always_comb begin
        if (rph_i == PH_W'(PH_A)) rdata_o = '0;
        else                      rdata_o = mem[rop_i][rph_i - PH_W'(1)];
    end
endmodule

// File: rtl/ucd_branch.sv
// Program-counter load decision from the jump bits of the current entry.
// Assumes the flags are already settled by the instruction before.
module ucd_branch
    import ucd_pkg::*;
(
    input  logic [3:0]      jbits_i,  // {jump, cond_gt, cond_eq, cond_lt}
    input  logic [PH_W-1:0] phase_i,
    input  logic            trig_i,
    input  logic            gt_i,
    input  logic            eq_i,
    input  logic            lt_i,
    output logic            load_o
);
    logic cond_hit;

    // Raise a load only in phase D under the strobe, on jump or enabled flag.
    always_comb begin
        cond_hit = |(jbits_i[2:0] & {gt_i, eq_i, lt_i});
        load_o   = (phase_i == PH_W'(PH_D)) && trig_i && (jbits_i[3] || cond_hit);
    end
endmodule

// File: rtl/ucode_decoder.sv
// Top of the phase-indexed microcode decoder. Splits the instruction word,
// reads the control table and resolves the jump request. All outputs are
// combinational from the inputs and the table state.
module ucode_decoder
    import ucd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [PH_W-1:0]    phase_i,
    input  logic               trig_i,
    input  logic               flag_gt_i,
    input  logic               flag_eq_i,
    input  logic               flag_lt_i,
    input  logic               tbl_we_i,
    input  logic [OP_W-1:0]    tbl_op_i,
    input  logic [PH_W-1:0]    tbl_ph_i,
    input  logic [CTRL_W-1:0]  tbl_data_i,
    output logic [CTRL_W-1:0]  ctrl_o,
    output logic               pc_load_o,
    output logic [ARG_W-1:0]   pc_target_o
);
    logic [OP_W-1:0]   opcode;
    logic [CTRL_W-1:0] entry;

    // Field split: opcode on top, operand below.
    always_comb begin
        opcode      = instr_i[INSTR_W-1:ARG_W];
        pc_target_o = instr_i[ARG_W-1:0];
    end

    ucd_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (tbl_we_i),
        .wop_i   (tbl_op_i),
        .wph_i   (tbl_ph_i),
        .wdata_i (tbl_data_i),
        .rop_i   (opcode),
        .rph_i   (phase_i),
        .rdata_o (entry)
    );

    ucd_branch u_branch (
        .jbits_i (entry[BIT_JMP:BIT_CLT]),
        .phase_i (phase_i),
        .trig_i  (trig_i),
        .gt_i    (flag_gt_i),
        .eq_i    (flag_eq_i),
        .lt_i    (flag_lt_i),
        .load_o  (pc_load_o)
    );

    // Drive the control lines straight from the selected entry.
    always_comb ctrl_o = entry;
endmodule

// File: rtl/ucd_checker.sv
// Property checker for ucode_decoder, attached by bind below.
module ucd_checker
    import ucd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic [PH_W-1:0]   phase_i,
    input logic              trig_i,
    input logic              gt_i,
    input logic              eq_i,
    input logic              lt_i,
    input logic              we_i,
    input logic [OP_W-1:0]   wop_i,
    input logic [PH_W-1:0]   wph_i,
    input logic [CTRL_W-1:0] wdata_i,
    input logic [CTRL_W-1:0] ctrl_i,
    input logic              load_i
);
    // R2: phase A is silent.
    p_phase_a_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 2'd0) |-> (ctrl_i == '0 && !load_i));

    // R10: a load needs the strobe and phase D.
    p_load_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (trig_i && phase_i == 2'd3));

    // R7/R8: a load has a cause in the visible control lines.
    p_load_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (ctrl_i[BIT_JMP] || (|(ctrl_i[BIT_CGT:BIT_CLT] & {gt_i, eq_i, lt_i}))));

    // R9: no cause in phase D under the strobe means no load.
    p_false_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 2'd3 && trig_i && !ctrl_i[BIT_JMP]
         && ((ctrl_i[BIT_CGT:BIT_CLT] & {gt_i, eq_i, lt_i}) == 3'b000)) |-> !load_i);

    // R5: a written entry reads back on the next cycle when addressed.
    p_write_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wph_i != 2'd0) |=>
        (!(op_i == $past(wop_i) && phase_i == $past(wph_i)) || ctrl_i == $past(wdata_i)));
endmodule

bind ucode_decoder ucd_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (instr_i[7:5]),
    .phase_i (phase_i),
    .trig_i  (trig_i),
    .gt_i    (flag_gt_i),
    .eq_i    (flag_eq_i),
    .lt_i    (flag_lt_i),
    .we_i    (tbl_we_i),
    .wop_i   (tbl_op_i),
    .wph_i   (tbl_ph_i),
    .wdata_i (tbl_data_i),
    .ctrl_i  (ctrl_o),
    .load_i  (pc_load_o)
);

// File: tb/sim_ucode_decoder.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops and compares.
module sim_ucode_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  instr = '0;
    logic [1:0]  phase = '0;
    logic        trig = 1'b0;
    logic        gt = 1'b0, eq = 1'b0, lt = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  wop = '0;
    logic [1:0]  wph = '0;
    logic [15:0] wdata = '0;
    logic [15:0] ctrl;
    logic        pc_load;
    logic [4:0]  pc_target;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] model [8][4];
    logic [15:0] q_ctrl[$];
    logic        q_load[$];
    logic [4:0]  q_tgt[$];
    string       q_req[$];

    always #2.5 clk = ~clk;

    ucode_decoder u0 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .phase_i(phase), .trig_i(trig),
        .flag_gt_i(gt), .flag_eq_i(eq), .flag_lt_i(lt),
        .tbl_we_i(we), .tbl_op_i(wop), .tbl_ph_i(wph), .tbl_data_i(wdata),
        .ctrl_o(ctrl), .pc_load_o(pc_load), .pc_target_o(pc_target)
    );

    // Default content as required by R4.
    task automatic model_reset();
        for (int o = 0; o < 8; o++) begin
            model[o][0] = '0;
            for (int p = 1; p < 4; p++) begin
                model[o][p] = '0;
                if (o < 6)       model[o][p] = 16'h1 << ((3 * o + p - 1) % 12);
                else if (p == 3) model[o][p] = (o == 6) ? 16'h8000 : 16'h7000;
            end
        end
    endtask

    // Drive one cycle and push its expected result; update the model after.
    task automatic step(input logic [2:0] op, input logic [4:0] arg, input logic [1:0] ph,
                        input logic tg, input logic [2:0] flg,
                        input logic w, input logic [2:0] wo, input logic [1:0] wp,
                        input logic [15:0] wd, input string req);
        logic [15:0] e;
        logic        l;
        @(negedge clk);
        instr = {op, arg}; phase = ph; trig = tg; {gt, eq, lt} = flg;
        we = w; wop = wo; wph = wp; wdata = wd;
        e = (ph == 2'd0) ? 16'h0 : model[op][ph];
        l = (ph == 2'd3) && tg && (e[15] || (|(e[14:12] & flg)));
        q_ctrl.push_back(e); q_load.push_back(l); q_tgt.push_back(arg); q_req.push_back(req);
        if (w && wp != 2'd0) model[wo][wp] = wd;
    endtask

    task automatic rd(input logic [2:0] op, input logic [4:0] arg, input logic [1:0] ph,
                      input logic tg, input logic [2:0] flg, input string req);
        step(op, arg, ph, tg, flg, 1'b0, 3'd0, 2'd0, 16'h0, req);
    endtask

    // Monitor: compare outputs mid-cycle against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q_ctrl.size() > 0) begin
                logic [15:0] ec;
                logic        el;
                logic [4:0]  et;
                string       r;
                ec = q_ctrl.pop_front(); el = q_load.pop_front();
                et = q_tgt.pop_front();  r  = q_req.pop_front();
                tests++;
                if (ctrl !== ec) begin
                    fails++;
                    $display("FAIL %s ctrl actual=%h expected=%h", r, ctrl, ec);
                end
                tests++;
                if (pc_load !== el) begin
                    fails++;
                    $display("FAIL %s pc_load actual=%b expected=%b", r, pc_load, el);
                end
                tests++;
                if (pc_target !== et) begin
                    fails++;
                    $display("FAIL R1 (%s) target actual=%h expected=%h", r, pc_target, et);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #500000;
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4, R3, R2: default table over every opcode and phase, flags clear.
        for (int o = 0; o < 8; o++)
            for (int p = 0; p < 4; p++)
                rd(3'(o), 5'(o * 3 + p), 2'(p), 1'b1, 3'b000,
                   (p == 0) ? "R2 phase A" : ((o == 6 && p == 3) ? "R7 jump" :
                   ((o == 7 && p == 3) ? "R9 no flag" : "R4 default")));

        // R8: each flag alone enables the conditional jump of opcode 7.
        rd(3'd7, 5'd17, 2'd3, 1'b1, 3'b100, "R8 gt");
        rd(3'd7, 5'd18, 2'd3, 1'b1, 3'b010, "R8 eq");
        rd(3'd7, 5'd31, 2'd3, 1'b1, 3'b001, "R8 lt");
        // R10: no strobe, or a phase other than D, blocks loads.
        rd(3'd7, 5'd5, 2'd3, 1'b0, 3'b111, "R10 no trig");
        rd(3'd6, 5'd6, 2'd3, 1'b0, 3'b000, "R10 no trig jump");
        step(3'd0, 5'd0, 2'd0, 1'b0, 3'b000, 1'b1, 3'd2, 2'd1, 16'h8000, "R5 write B");
        rd(3'd2, 5'd9, 2'd1, 1'b1, 3'b111, "R10 jump bit in B");

        // R5: write the entry under decode; old in write cycle, new after.
        step(3'd3, 5'd12, 2'd3, 1'b1, 3'b000, 1'b1, 3'd3, 2'd3, 16'hABCD, "R5 old");
        rd(3'd3, 5'd12, 2'd3, 1'b1, 3'b000, "R5 new");
        rd(3'd3, 5'd12, 2'd3, 1'b0, 3'b000, "R10 new entry no trig");

        // Jump coinciding with a write elsewhere.
        step(3'd6, 5'd21, 2'd3, 1'b1, 3'b000, 1'b1, 3'd1, 2'd2, 16'h00F0, "R7 with write");
        rd(3'd1, 5'd2, 2'd2, 1'b1, 3'b000, "R5 other entry");

        // R6: a write to phase code 0 changes nothing.
        step(3'd4, 5'd0, 2'd1, 1'b1, 3'b000, 1'b1, 3'd4, 2'd0, 16'hFFFF, "R6 write A");
        rd(3'd4, 5'd1, 2'd1, 1'b1, 3'b000, "R6 B kept");
        rd(3'd4, 5'd2, 2'd2, 1'b1, 3'b000, "R6 C kept");
        rd(3'd4, 5'd3, 2'd3, 1'b1, 3'b111, "R6 D kept");
        rd(3'd4, 5'd4, 2'd0, 1'b1, 3'b111, "R2 phase A after write");

        // R8/R9: eq-only condition, tested against each flag.
        step(3'd0, 5'd0, 2'd0, 1'b0, 3'b000, 1'b1, 3'd0, 2'd3, 16'h2000, "R5 write cond");
        rd(3'd0, 5'd10, 2'd3, 1'b1, 3'b100, "R9 gt not enabled");
        rd(3'd0, 5'd11, 2'd3, 1'b1, 3'b001, "R9 lt not enabled");
        rd(3'd0, 5'd12, 2'd3, 1'b1, 3'b010, "R8 eq enabled");
        rd(3'd0, 5'd13, 2'd2, 1'b1, 3'b010, "R10 phase C");

        // R4: reset restores the defaults.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        rd(3'd3, 5'd7, 2'd3, 1'b1, 3'b000, "R4 reset restores");
        rd(3'd0, 5'd8, 2'd3, 1'b1, 3'b010, "R4 reset cond");
        rd(3'd2, 5'd9, 2'd1, 1'b1, 3'b000, "R4 reset B");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule